// File: doc/BRIEF.md
# Transmit Framing-Bit Error Injector

This block sits in a T1 transmit path, just ahead of line coding. It turns a serial transmit stream into a test stream by inverting chosen framing bits, so that the far end can be driven into loss of frame or shown a steady trickle of framing errors. Framing-pattern generation, CRC6 computation and line coding are done elsewhere. The internally generated framing bit reaches this block as an input, together with strobes that mark F-bit time, framing-pattern positions and CRC6 positions.

It offers two injection modes that work independently of each other. The burst mode is armed by a rising edge on its control and inverts the next three framing-pattern bits. The periodic mode inverts one framing-pattern bit in every 128 for as long as its control stays high. Framing-pattern bits are Ft bits in D4 framing and FPS bits in ESF framing. A pass-through option takes the F bit from the serial input instead of the internal source. In ESF, a second option takes only the CRC6 positions from the serial input.

Top module: `fbit_err_inject`

## Requirements
- R1: A bit presented with `fbit_time` low appears unchanged on `tx_out` one clock later.
- R2: At F-bit time, the source bit is `int_fbit` while `fpass_en` is 0, and `ser_in` while `fpass_en` is 1. It is output one clock later, inverted only when an injection mode selects it.
- R3: With `esf_mode`=1 and `crcpass_en`=1, an F bit marked by `crc_pos` takes its value from `ser_in`. With `esf_mode`=0, `crcpass_en` has no effect.
- R4: A 0-to-1 change on `burst_ctl` inverts exactly the next 3 framing-pattern bits, which are F bits with `pat_bit`=1. F bits with `pat_bit`=0 are neither counted nor inverted.
- R5: While `burst_ctl` stays high after a burst has ended, no further bit is inverted. A new burst needs `burst_ctl` to go low and then rise again.
- R6: After `period_ctl` rises, the 128th framing-pattern bit is inverted, and then every 128th one after it while the control stays high.
- R7: While `period_ctl` is low, the periodic mode inverts nothing. Raising it again restarts the count at zero.
- R8: A framing-pattern bit selected by both modes at once is inverted once, not twice.
- R9: When `rst_n` is low, `tx_out` is 0 and any armed burst or partial periodic count is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_in | input | 1 | Serial transmit data, including externally supplied F/CRC bits |
| int_fbit | input | 1 | Internally generated framing bit |
| fbit_time | input | 1 | High when the current bit is an F bit |
| pat_bit | input | 1 | High when the F bit is a framing-pattern bit (Ft or FPS) |
| crc_pos | input | 1 | High when the F bit is a CRC6 position (ESF) |
| esf_mode | input | 1 | 1 = ESF framing, 0 = D4 framing |
| fpass_en | input | 1 | Take every F bit from `ser_in` |
| crcpass_en | input | 1 | Take ESF CRC6 positions from `ser_in` |
| burst_ctl | input | 1 | Rising edge arms a 3-bit corruption burst |
| period_ctl | input | 1 | High enables 1-in-128 corruption |
| tx_out | output | 1 | Transmit stream, registered |

## Verification
The assertions assume that `pat_bit` and `crc_pos` are meaningful only while `fbit_time` is high. They also assume that the two corruption controls change only between bits, so that an edge is sampled on exactly one clock. The bench drives every input at the falling edge from a framing sequence that marks every second F bit as a pattern bit in D4. In ESF it marks one F bit in four as a pattern bit and another one in four as a CRC position. Each control edge falls on a payload bit, so no edge coincides with a pattern bit, and reset is applied with both controls low.

// File: rtl/fbi_pkg.sv
package fbi_pkg;
  // Per-bit slot qualifiers presented alongside the serial data.
  typedef struct packed {
    logic fbit;  // F-bit time
    logic pat;   // framing-pattern position
    logic crc;   // CRC6 position
  } fslot_t;

  localparam int unsigned DEF_BURST_LEN = 3;
  localparam int unsigned DEF_PERIOD    = 128;
endpackage

// File: rtl/fbi_burst_arm.sv
module fbi_burst_arm #(
  parameter int unsigned BURST_LEN = fbi_pkg::DEF_BURST_LEN
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ctl,
  input  logic strobe,
  output logic hit
);
  localparam int unsigned CW = $clog2(BURST_LEN + 1);

  logic          ctl_q;
  logic [CW-1:0] rem_q, rem_d;
  logic          rise, rem_en;

  assign rise   = ctl & ~ctl_q;
  assign rem_en = rise | (strobe & (rem_q != '0));

  always_comb begin
    rem_d = rem_q;
    if (rise)
      rem_d = CW'(BURST_LEN);
    else if (strobe && (rem_q != '0))
      rem_d = rem_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= 1'b0;
      rem_q <= '0;
    end else begin
      ctl_q <= ctl;
      if (rem_en) rem_q <= rem_d;
    end
  end

  assign hit = strobe & (rem_q != '0);

  // R4
  burst_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl && !ctl_q) |=> (rem_q == CW'(BURST_LEN)));
  // R4
  burst_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rem_q <= CW'(BURST_LEN));
  // R5
  burst_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl && ctl_q && rem_q == '0) |=> (rem_q == '0));
endmodule

// File: rtl/fbi_period_gen.sv
module fbi_period_gen #(
  parameter int unsigned PERIOD = fbi_pkg::DEF_PERIOD
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ctl,
  input  logic strobe,
  output logic hit
);
  localparam int unsigned CW = $clog2(PERIOD);
  localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

  logic          ctl_q;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          rise, cnt_en;

  assign rise   = ctl & ~ctl_q;
  assign cnt_en = rise | (ctl & strobe);

  always_comb begin
    cnt_d = cnt_q;
    if (rise)
      cnt_d = '0;
    else if (ctl && strobe)
      cnt_d = (cnt_q == LAST) ? '0 : cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      ctl_q <= ctl;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign hit = ctl & ctl_q & strobe & (cnt_q == LAST);

  // R7
  period_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl && !ctl_q) |=> (cnt_q == '0));
  // R6
  period_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl && ctl_q && strobe && cnt_q != LAST) |=> (cnt_q == $past(cnt_q) + CW'(1)));
  // R6
  period_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> (cnt_q == '0));
endmodule

// File: rtl/fbi_fbit_mux.sv
module fbi_fbit_mux
  import fbi_pkg::*;
(
  input  fslot_t slot,
  input  logic   ser_in,
  input  logic   int_fbit,
  input  logic   esf_mode,
  input  logic   fpass_en,
  input  logic   crcpass_en,
  output logic   src_bit
);
  logic take_ser;

  always_comb begin
    take_ser = fpass_en | (esf_mode & crcpass_en & slot.crc);
    if (!slot.fbit)
      src_bit = ser_in;
    else
      src_bit = take_ser ? ser_in : int_fbit;
  end
endmodule

// File: rtl/fbit_err_inject.sv
module fbit_err_inject
  import fbi_pkg::*;
#(
  parameter int unsigned BURST_LEN = DEF_BURST_LEN,
  parameter int unsigned PERIOD    = DEF_PERIOD
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ser_in,
  input  logic int_fbit,
  input  logic fbit_time,
  input  logic pat_bit,
  input  logic crc_pos,
  input  logic esf_mode,
  input  logic fpass_en,
  input  logic crcpass_en,
  input  logic burst_ctl,
  input  logic period_ctl,
  output logic tx_out
);
  fslot_t slot;
  logic   strobe, src_bit, b_hit, p_hit, out_d, out_q;

  assign slot   = '{fbit: fbit_time, pat: pat_bit, crc: crc_pos};
  assign strobe = fbit_time & pat_bit;

  fbi_fbit_mux u_mux (
    .slot(slot), .ser_in(ser_in), .int_fbit(int_fbit), .esf_mode(esf_mode),
    .fpass_en(fpass_en), .crcpass_en(crcpass_en), .src_bit(src_bit)
  );

  fbi_burst_arm #(.BURST_LEN(BURST_LEN)) u_burst (
    .clk(clk), .rst_n(rst_n), .ctl(burst_ctl), .strobe(strobe), .hit(b_hit)
  );

  fbi_period_gen #(.PERIOD(PERIOD)) u_period (
    .clk(clk), .rst_n(rst_n), .ctl(period_ctl), .strobe(strobe), .hit(p_hit)
  );

  // Single inversion when either mode selects the bit.
  assign out_d = src_bit ^ (b_hit | p_hit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_q <= 1'b0;
    else        out_q <= out_d;
  end

  assign tx_out = out_q;

  // R1
  payload_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fbit_time |=> (tx_out == $past(ser_in)));
  // R8
  single_inv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (b_hit && p_hit) |=> (tx_out != $past(src_bit)));
  // R4
  hit_on_pattern_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (b_hit || p_hit) |-> strobe);
  // R7
  quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!period_ctl && !b_hit) |=> (tx_out == $past(src_bit)));
endmodule

// File: tb/fbit_err_inject_bench.sv
`timescale 1ns/1ps
module fbit_err_inject_bench;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, ser_in, int_fbit, fbit_time, pat_bit, crc_pos;
  logic esf_mode, fpass_en, crcpass_en, burst_ctl, period_ctl, tx_out;

  fbit_err_inject u_fbit_err_inject (
    .clk(clk), .rst_n(rst_n), .ser_in(ser_in), .int_fbit(int_fbit),
    .fbit_time(fbit_time), .pat_bit(pat_bit), .crc_pos(crc_pos),
    .esf_mode(esf_mode), .fpass_en(fpass_en), .crcpass_en(crcpass_en),
    .burst_ctl(burst_ctl), .period_ctl(period_ctl), .tx_out(tx_out)
  );

  int errors = 0, checks = 0, hits = 0, fidx = 0;
  int m_brem = 0, m_pcnt = 0;
  logic m_bprev = 1'b0, m_pprev = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // One bit slot: drive at falling edge, expected value from the requirements.
  task automatic step(input logic fb, input logic pt, input logic cr);
    logic s, src, hb, hp, stb, exp;
    string tag;
    @(negedge clk);
    s = lfsr[0];
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    ser_in = s; int_fbit = lfsr[3];
    fbit_time = fb; pat_bit = pt; crc_pos = cr;
    src = !fb ? s : ((fpass_en || (esf_mode && crcpass_en && cr)) ? s : lfsr[3]);
    stb = fb && pt;
    hb = stb && (m_brem > 0);
    hp = period_ctl && m_pprev && stb && (m_pcnt == 127);
    if (burst_ctl && !m_bprev) m_brem = 3;
    else if (stb && m_brem > 0) m_brem--;
    m_bprev = burst_ctl;
    if (period_ctl && !m_pprev) m_pcnt = 0;
    else if (period_ctl && stb) m_pcnt = (m_pcnt == 127) ? 0 : m_pcnt + 1;
    m_pprev = period_ctl;
    exp = src ^ (hb | hp);
    if (hb | hp) hits++;
    if (!fb) tag = "R1 payload";
    else if (hb && hp) tag = "R8 overlap";
    else if (hb) tag = "R4 burst";
    else if (hp) tag = "R6 periodic";
    else if (esf_mode && crcpass_en && cr) tag = "R3 crc pass";
    else tag = "R2 fbit source";
    @(posedge clk); #1;
    chk(tag, int'(tx_out), int'(exp));
  endtask

  // Run until n framing-pattern bits have gone by; payload slot between F bits.
  task automatic run_pat(input int n);
    int got = 0;
    while (got < n) begin
      logic pt, cr;
      step(1'b0, 1'b0, 1'b0);
      if (esf_mode) begin pt = (fidx % 4 == 3); cr = (fidx % 4 == 1); end
      else begin pt = (fidx % 2 == 1); cr = 1'b0; end
      step(1'b1, pt, cr);
      fidx++;
      if (pt) got++;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; burst_ctl = 1'b0; period_ctl = 1'b0;
    repeat (2) @(posedge clk);
    #1 chk("R9 reset output", int'(tx_out), 0);
    m_brem = 0; m_pcnt = 0; m_bprev = 1'b0; m_pprev = 1'b0;
    @(negedge clk) rst_n = 1'b1;
  endtask

  initial begin
    #(200000 * 5.0);
    errors++; checks++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    ser_in = 0; int_fbit = 0; fbit_time = 0; pat_bit = 0; crc_pos = 0;
    esf_mode = 0; fpass_en = 0; crcpass_en = 0; burst_ctl = 0; period_ctl = 0;
    rst_n = 1'b0;
    do_reset();

    // R1, R2: D4 internal source, then pass-through
    for (int m = 0; m < 2; m++) begin
      esf_mode = m[0];
      fpass_en = 0; run_pat(20);
      fpass_en = 1; run_pat(20);
      fpass_en = 0;
    end
    // R3: CRC pass in ESF, ignored in D4
    crcpass_en = 1;
    esf_mode = 1; run_pat(20);
    esf_mode = 0; run_pat(20);
    crcpass_en = 0;

    // R4, R5: bursts in both framing modes
    for (int m = 0; m < 2; m++) begin
      esf_mode = m[0];
      hits = 0; burst_ctl = 1; step(0, 0, 0);
      run_pat(10);
      chk("R4 burst count", hits, 3);
      hits = 0; run_pat(20);
      chk("R5 held high no rearm", hits, 0);
      burst_ctl = 0; step(0, 0, 0);
      hits = 0; burst_ctl = 1; step(0, 0, 0);
      run_pat(8);
      chk("R5 rearm after low", hits, 3);
      burst_ctl = 0; step(0, 0, 0);
    end

    // R6: periodic, first at 128th then every 128
    esf_mode = 0;
    hits = 0; period_ctl = 1; step(0, 0, 0);
    run_pat(127);
    chk("R6 none before 128th", hits, 0);
    run_pat(1);
    chk("R6 128th inverted", hits, 1);
    run_pat(128);
    chk("R6 second period", hits, 2);
    // R7: drop low mid count, then restart from zero
    run_pat(60);
    period_ctl = 0; step(0, 0, 0);
    hits = 0; run_pat(150);
    chk("R7 low no inversion", hits, 0);
    period_ctl = 1; step(0, 0, 0);
    run_pat(127);
    chk("R7 restart count", hits, 0);
    run_pat(1);
    chk("R7 restart 128th", hits, 1);
    period_ctl = 0; step(0, 0, 0);

    // R8: burst overlaps periodic 128th bit
    esf_mode = 1;
    period_ctl = 1; step(0, 0, 0);
    run_pat(127);
    hits = 0; burst_ctl = 1; step(0, 0, 0);
    run_pat(3);
    chk("R8 overlap count", hits, 3);
    burst_ctl = 0; period_ctl = 0; step(0, 0, 0);

    // R9: reset discards an armed burst
    burst_ctl = 1; step(0, 0, 0);
    do_reset();
    hits = 0; run_pat(10);
    chk("R9 burst discarded", hits, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule